// File: doc/BRIEF.md
# DMA Translation Configuration Register File

This block holds the two configuration words of a DMA address-translation unit: a 64-bit control word and a 64-bit translation-table base address. Software reaches them through a simple memory-mapped port that carries a byte offset, write data, a write strobe, a size flag (four or eight bytes) and registered read data. The stored fields go straight to the translation datapath. These are the enable bit, the table-walk page size, the table-size code and the table base.

Each 64-bit word can be reached whole, or as two 32-bit halves in big-endian order. At the word's own offset, a 32-bit access reaches the most significant half. At that offset plus four, it reaches the least significant half. A third word, at offset 0x10, is a flush command slot. It accepts writes and does nothing with them, and it reads as zero. Every other offset is empty.

Top module: `iommu_cfg_regs`

## Requirements
- R1: After reset both stored words are zero, every translation output is zero (translation disabled), and all reads return zero.
- R2: An 8-byte write (bus_sz64=1) at offset 0x0 or 0x8 replaces the whole addressed word with bus_wdata. An 8-byte read at those offsets returns the whole word.
- R3: A 4-byte write (bus_sz64=0) at offset 0x0 or 0x8 loads bus_wdata[31:0] into bits 63:32 of the addressed word and leaves bits 31:0 unchanged.
- R4: A 4-byte write at offset 0x4 or 0xC loads bus_wdata[31:0] into bits 31:0 of the word below it and leaves bits 63:32 unchanged.
- R5: A 4-byte read at 0x0 or 0x8 returns bits 63:32 of the word on bus_rdata[31:0]. A 4-byte read at 0x4 or 0xC returns bits 31:0. In both cases bus_rdata[63:32] is zero.
- R6: Writes to the flush slot (0x10 with either size, or 0x14 with 4 bytes) change no stored state, and reads there return zero.
- R7: Offsets 0x18 and above, 8-byte accesses whose offset is not a multiple of 8, and 4-byte accesses whose offset is not a multiple of 4 are unimplemented. They read zero, and writes to them are dropped.
- R8: xlat_en_o is control bit 0, page64k_o is control bit 2, tbl_size_o is control bits 18:16, and tbl_base_o is the base word. Each reflects a write on the clock edge that samples the strobe.
- R9: bus_rdata shows, one clock after an offset and size are presented, the contents held before that edge. A write in the same cycle shows up only on a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_sz64 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data; 4-byte writes use bits 31:0 |
| bus_rdata | output | 64 | Registered read data |
| xlat_en_o | output | 1 | Translation enable |
| page64k_o | output | 1 | Table-walk page size: 1 = 64K, 0 = 8K |
| tbl_size_o | output | 3 | Table-size code |
| tbl_base_o | output | 64 | Translation table base address |

## Verification
A wrong half-word merge or a stray decode hit corrupts the stored words. The corruption shows on tbl_base_o or on the control outputs at the very next edge, so the bench compares all of those ports after every write. A wrong read mux or wrong lane placement shows on bus_rdata one cycle after the access. For that reason reads at every offset and size, both aligned and misaligned, are compared against a bench-side model of both words. Writes to the flush slot and to empty offsets are followed by full reads, which expose any side effect at once.

// File: rtl/iommu_cfg_pkg.sv
package iommu_cfg_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = WORD_W / 2;
    localparam int NUM_REGS = 2;

    // Control word field positions used by the translation datapath.
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_PG_BIT    = 2;
    localparam int CTL_SIZE_LSB  = 16;
    localparam int CTL_SIZE_W    = 3;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_FLUSH = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        LANE_FULL = 2'd0,
        LANE_HI   = 2'd1,
        LANE_LO   = 2'd2,
        LANE_NONE = 2'd3
    } lane_e;

    typedef struct packed {
        reg_sel_e sel;
        lane_e    lane;
    } dec_t;

endpackage

// File: rtl/iommu_cfg_decode.sv
module iommu_cfg_decode
    import iommu_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sz64,
    output dec_t              dec
);

    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] word_idx;
    logic [2:0]       byte_off;
    lane_e            lane_c;
    reg_sel_e         sel_c;

    assign word_idx = addr[ADDR_W-1:3];
    assign byte_off = addr[2:0];

    always_comb begin
        if (sz64) begin
            lane_c = (byte_off == 3'd0) ? LANE_FULL : LANE_NONE;
        end else if (byte_off[1:0] != 2'd0) begin
            lane_c = LANE_NONE;
        end else begin
            lane_c = byte_off[2] ? LANE_LO : LANE_HI;
        end
    end

    always_comb begin
        if (word_idx == IDX_W'(0)) begin
            sel_c = SEL_CTRL;
        end else if (word_idx == IDX_W'(1)) begin
            sel_c = SEL_BASE;
        end else if (word_idx == IDX_W'(2)) begin
            sel_c = SEL_FLUSH;
        end else begin
            sel_c = SEL_NONE;
        end
    end

    always_comb begin
        dec.lane = lane_c;
        dec.sel  = (lane_c == LANE_NONE) ? SEL_NONE : sel_c;
    end

endmodule

// File: rtl/iommu_cfg_word.sv
module iommu_cfg_word
    import iommu_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  lane_e             lane,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_q
);

    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            case (lane)
                LANE_FULL: word_d = wdata;
                LANE_HI:   word_d[WORD_W-1:HALF_W] = wdata[HALF_W-1:0];
                LANE_LO:   word_d[HALF_W-1:0]      = wdata[HALF_W-1:0];
                default:   word_d = word_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane == LANE_FULL) |=> (word_q == $past(wdata))); // R2

    AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane == LANE_HI) |=> (word_q[HALF_W-1:0] == $past(word_q[HALF_W-1:0]))); // R3

    AST_LO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane == LANE_LO) |=> (word_q[WORD_W-1:HALF_W] == $past(word_q[WORD_W-1:HALF_W]))); // R4

endmodule

// File: rtl/iommu_cfg_regs.sv
module iommu_cfg_regs
    import iommu_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_sz64,
    input  logic              bus_we,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              xlat_en_o,
    output logic              page64k_o,
    output logic [2:0]        tbl_size_o,
    output logic [63:0]       tbl_base_o
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    dec_t              dec;
    logic [WORD_W-1:0] regs_q [NUM_REGS];
    rd_state_t         st_d, st_q;

    iommu_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sz64 (bus_sz64),
        .dec  (dec)
    );

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
        logic hit;
        assign hit = bus_we && (dec.sel == reg_sel_e'(gi));
        iommu_cfg_word u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (hit),
            .lane   (dec.lane),
            .wdata  (bus_wdata),
            .word_q (regs_q[gi])
        );
    end

    always_comb begin
        logic [WORD_W-1:0] src;
        st_d = st_q;
        src  = '0;
        case (dec.sel)
            SEL_CTRL: src = regs_q[0];
            SEL_BASE: src = regs_q[1];
            default:  src = '0;
        endcase
        case (dec.lane)
            LANE_FULL: st_d.rdata = src;
            LANE_HI:   st_d.rdata = {{HALF_W{1'b0}}, src[WORD_W-1:HALF_W]};
            LANE_LO:   st_d.rdata = {{HALF_W{1'b0}}, src[HALF_W-1:0]};
            default:   st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign xlat_en_o  = regs_q[0][CTL_EN_BIT];
    assign page64k_o  = regs_q[0][CTL_PG_BIT];
    assign tbl_size_o = regs_q[0][CTL_SIZE_LSB +: CTL_SIZE_W];
    assign tbl_base_o = regs_q[1];

    AST_FLUSH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_FLUSH) |=> (bus_rdata == '0)); // R6

    AST_FLUSH_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dec.sel == SEL_FLUSH) |=> ($stable(tbl_base_o) && $stable(xlat_en_o) && $stable(tbl_size_o))); // R6

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.sel == SEL_NONE) |=> (bus_rdata == '0)); // R7

    AST_EMPTY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && dec.sel == SEL_NONE) |=> ($stable(tbl_base_o) && $stable(page64k_o) && $stable(xlat_en_o))); // R7

    AST_HALF_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sz64) |=> (bus_rdata[63:32] == 32'd0)); // R5

    AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sz64 && bus_addr == ADDR_W'(0)) |=> (xlat_en_o == $past(bus_wdata[0]))); // R8

endmodule

// File: tb/sim_iommu_cfg_regs.sv
module sim_iommu_cfg_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_sz64 = 1'b0;
    logic        bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        xlat_en_o, page64k_o;
    logic [2:0]  tbl_size_o;
    logic [63:0] tbl_base_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [63:0] m_ctl = '0;
    logic [63:0] m_base = '0;

    always #10ns clk = ~clk;

    iommu_cfg_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_sz64(bus_sz64),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xlat_en_o(xlat_en_o), .page64k_o(page64k_o), .tbl_size_o(tbl_size_o),
        .tbl_base_o(tbl_base_o)
    );

    // lane: 0 full, 1 upper half, 2 lower half, 3 none; which: 0 ctl, 1 base, 2 other
    function automatic int lane_of(input logic [7:0] a, input logic s64);
        if (s64) return (a[2:0] == 3'd0) ? 0 : 3;
        if (a[1:0] != 2'd0) return 3;
        return a[2] ? 2 : 1;
    endfunction

    function automatic int word_of(input logic [7:0] a);
        if (a[7:3] == 5'd0) return 0;
        if (a[7:3] == 5'd1) return 1;
        return 2;
    endfunction

    function automatic logic [63:0] exp_read(input logic [7:0] a, input logic s64);
        logic [63:0] w;
        int ln;
        ln = lane_of(a, s64);
        if (ln == 3 || word_of(a) == 2) return 64'd0;
        w = (word_of(a) == 0) ? m_ctl : m_base;
        if (ln == 0) return w;
        if (ln == 1) return {32'd0, w[63:32]};
        return {32'd0, w[31:0]};
    endfunction

    function automatic logic [63:0] merged(input logic [63:0] w, input int ln, input logic [63:0] d);
        if (ln == 0) return d;
        if (ln == 1) return {d[31:0], w[31:0]};
        if (ln == 2) return {w[63:32], d[31:0]};
        return w;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check({req, " enable"}, {63'd0, xlat_en_o}, {63'd0, m_ctl[0]});
        check({req, " page"}, {63'd0, page64k_o}, {63'd0, m_ctl[2]});
        check({req, " size"}, {61'd0, tbl_size_o}, {61'd0, m_ctl[18:16]});
        check({req, " base"}, tbl_base_o, m_base);
    endtask

    task automatic wr(input logic [7:0] a, input logic s64, input logic [63:0] d);
        int ln;
        @(negedge clk);
        bus_addr = a; bus_sz64 = s64; bus_we = 1'b1; bus_wdata = d;
        ln = lane_of(a, s64);
        @(negedge clk);
        bus_we = 1'b0;
        if (ln != 3) begin
            if (word_of(a) == 0) m_ctl = merged(m_ctl, ln, d);
            else if (word_of(a) == 1) m_base = merged(m_base, ln, d);
        end
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic s64);
        logic [63:0] e;
        @(negedge clk);
        bus_addr = a; bus_sz64 = s64; bus_we = 1'b0;
        e = exp_read(a, s64);
        @(negedge clk);
        check(req, bus_rdata, e);
    endtask

    function automatic logic [7:0] pick_addr(input int k);
        case (k)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
            4: return 8'h10;  5: return 8'h14;  6: return 8'h18;  7: return 8'h02;
            8: return 8'h0A;  9: return 8'h09;  10: return 8'h80; default: return 8'hFC;
        endcase
    endfunction

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_outs("R1");
        rd("R1 ctl read", 8'h00, 1'b1);
        rd("R1 base read", 8'h08, 1'b1);

        // R2 full write/read
        wr(8'h00, 1'b1, 64'hDEAD_BEEF_0007_0005);
        check_outs("R2 R8 ctl full");
        rd("R2 ctl", 8'h00, 1'b1);
        wr(8'h08, 1'b1, 64'h0123_4567_89AB_C000);
        check_outs("R2 R8 base full");
        rd("R2 base", 8'h08, 1'b1);

        // R3 upper half write
        wr(8'h08, 1'b0, 64'hFFFF_FFFF_AAAA_5555);
        check_outs("R3 base upper");
        rd("R3 base", 8'h08, 1'b1);
        // R4 lower half write
        wr(8'h04, 1'b0, 64'h1111_1111_0006_0000);
        check_outs("R4 ctl lower");
        rd("R4 ctl", 8'h00, 1'b1);
        // R5 half reads
        rd("R5 ctl upper", 8'h00, 1'b0);
        rd("R5 ctl lower", 8'h04, 1'b0);
        rd("R5 base lower", 8'h0C, 1'b0);

        // R6 flush slot
        wr(8'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check_outs("R6 flush write");
        rd("R6 flush read", 8'h10, 1'b1);
        rd("R6 flush read lo", 8'h14, 1'b0);

        // R7 unimplemented / misaligned
        wr(8'h04, 1'b1, 64'h5555_5555_5555_5555);
        wr(8'h18, 1'b1, 64'h5555_5555_5555_5555);
        wr(8'h02, 1'b0, 64'h5555_5555_5555_5555);
        check_outs("R7 dropped");
        rd("R7 misaligned read", 8'h04, 1'b1);
        rd("R7 empty read", 8'h18, 1'b1);
        rd("R7 odd half read", 8'h0A, 1'b0);

        // R9 read during write returns old contents
        @(negedge clk);
        bus_addr = 8'h08; bus_sz64 = 1'b1; bus_we = 1'b1; bus_wdata = 64'hCAFE_0000_0000_2000;
        @(negedge clk);
        bus_we = 1'b0;
        check("R9 old on same-cycle write", bus_rdata, m_base);
        m_base = 64'hCAFE_0000_0000_2000;
        rd("R9 new after write", 8'h08, 1'b1);

        // R8 each control field
        wr(8'h04, 1'b0, 64'h0000_0000_0007_0004);
        check_outs("R8 fields");
        wr(8'h04, 1'b0, 64'h0000_0000_0002_0001);
        check_outs("R8 fields 2");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0]  a;
            logic        s;
            logic [63:0] d;
            a = pick_addr($urandom % 12);
            s = $urandom % 2;
            d = {$urandom, $urandom};
            if ($urandom % 2) begin
                wr(a, s, d);
                check_outs("R2 R3 R4 R6 R7 random write");
            end else begin
                rd("R5 R7 random read", a, s);
            end
        end

        // R1 again: reset clears
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_ctl = '0; m_base = '0;
        check_outs("R1 re-reset");
        rd("R1 re-reset read", 8'h08, 1'b1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule